// File: doc/BRIEF.md
# Auto-Indexed Pointer Load Unit

This unit carries out a 32-bit load through a base pointer register and then updates that pointer. It is built for a small processor whose general registers are 24 bits wide. The pointer can be adjusted in three ways:

- advanced after the access,
- pulled back after the access,
- pulled back before the access, in which case the read goes to the new address.

The distance the pointer moves depends on how many prefix words came before the load. With no prefix the unit moves it by the word size, 4 bytes. With one prefix it uses a short immediate, and with two prefixes it uses a full-width immediate.

The decoder presents one request on a single-cycle `start` strobe. The request carries:

- the mode,
- the destination and base register indices,
- the number of prefixes,
- the assembled immediate,
- the current value of the base register, read from the register file.

The unit then runs for two cycles. In the first cycle it issues a memory read. In the second it returns two register-file writes: the low 24 bits of the loaded word go to the destination, and the new pointer value goes to the base register. The register file itself sits outside the unit.

Top module: `autoidx_load_unit`

## Requirements
- R1: After reset, `busy`, `memReq`, `done`, `dstWe` and `ptrWe` are all 0.
- R2: Mode code 0 (post-increment) reads at the base value and writes base + step to the base register.
- R3: Mode code 1 (post-decrement) reads at the base value and writes base - step to the base register.
- R4: Mode code 2 (pre-decrement) reads at base - step and writes that same value to the base register.
- R5: The step size depends on `extCount`:
  - 0: the step is 4.
  - 1: the step is bits 12:0 of `extImm`, zero-extended; bits 23:13 are ignored.
  - 2 or 3: the step is all 24 bits of `extImm`.
- R6: All pointer arithmetic wraps modulo 2^24.
- R7: The destination receives bits 23:0 of `memData`. Bits 31:24 are discarded.
- R8: A request is accepted only in the idle state.
  - In the cycle after acceptance, `memReq` and `busy` are 1.
  - In the cycle after that, `done`, `dstWe` and (unless R9 applies) `ptrWe` are 1 for exactly one cycle, with `busy` still 1.
  - `busy` is 0 in the cycle after that.
- R9: When the destination index equals the base index, only the destination write is issued, so the loaded data wins.
- R10: A `start` that arrives while `busy` is 1 is ignored. It causes no read and no register write.
- R11: A request with mode code 3 is ignored. The unit stays idle and causes no read and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe |
| mode | input | 2 | 0 post-increment, 1 post-decrement, 2 pre-decrement, 3 reserved |
| dstSel | input | 3 | Destination register index |
| baseSel | input | 3 | Base register index |
| extCount | input | 2 | Number of prefix words before the load |
| extImm | input | 24 | Immediate assembled from the prefix words |
| baseVal | input | 24 | Current value of the base register |
| memReq | output | 1 | Memory read request |
| memAddr | output | 24 | Read address |
| memData | input | 32 | Read data, valid while memReq is 1 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Commit cycle |
| dstWe | output | 1 | Destination write enable |
| dstIdx | output | 3 | Destination write index |
| dstData | output | 24 | Destination write data |
| ptrWe | output | 1 | Base write enable |
| ptrIdx | output | 3 | Base write index |
| ptrData | output | 24 | Updated pointer value |

## Verification
The bench uses pre-decrement to catch a design that reads at the old pointer: such a design would load a different word from the one written back as the new pointer. It uses a single-prefix immediate with high bits set to expose a step that is not masked to 13 bits. It uses pointers near zero and near the top of the 24-bit range to catch arithmetic that fails to wrap. It also runs a load whose destination is its own base register, where a wrong write priority would leave the pointer in place of the data. Finally, it holds `start` high through a busy operation and sends a reserved mode code, either of which would produce a spurious read or a corrupted register.

// File: rtl/aidx_pkg.sv
package aidx_pkg;

  typedef enum logic [1:0] {
    MODE_POST_INC = 2'd0,
    MODE_POST_DEC = 2'd1,
    MODE_PRE_DEC  = 2'd2,
    MODE_RSVD     = 2'd3
  } idxMode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_COMMIT = 2'd2
  } seqState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latchOp;      // take a new request
    logic captureData;  // take read data at end of issue cycle
  } dpStrobe_t;

endpackage

// File: rtl/aidx_ctrl.sv
module aidx_ctrl
  import aidx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  idxMode_e  mode,
  input  logic      sameIdx,
  output dpStrobe_t strb,
  output logic      memReq,
  output logic      busy,
  output logic      done,
  output logic      dstWe,
  output logic      ptrWe
);

  seqState_e state, stateNext;
  logic      accept;

  assign accept = (state == ST_IDLE) && start && (mode != MODE_RSVD);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNext = ST_ISSUE;
      ST_ISSUE:  stateNext = ST_COMMIT;
      ST_COMMIT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.latchOp     = accept;
    strb.captureData = (state == ST_ISSUE);
  end

  assign memReq = (state == ST_ISSUE);
  assign done   = (state == ST_COMMIT);
  assign busy   = (state != ST_IDLE);
  assign dstWe  = done;
  assign ptrWe  = done && !sameIdx;

endmodule

// File: rtl/aidx_datapath.sv
module aidx_datapath
  import aidx_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int REG_CNT     = 8,
  parameter int SHORT_IMM_W = 13,
  parameter int UNIT_STEP   = 4,
  localparam int IDX_W      = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  idxMode_e          mode,
  input  logic [1:0]        extCount,
  input  logic [ADDR_W-1:0] extImm,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IDX_W-1:0]  dstSel,
  input  logic [IDX_W-1:0]  baseSel,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] ptrData,
  output logic [ADDR_W-1:0] dstData,
  output logic [IDX_W-1:0]  ptrIdx,
  output logic [IDX_W-1:0]  dstIdx,
  output logic              sameIdx
);

  localparam int PAD_W = ADDR_W - SHORT_IMM_W;

  logic [ADDR_W-1:0] step, sumPtr, diffPtr, nextPtr, accAddr;
  logic [ADDR_W-1:0] addrQ, ptrQ, dataQ;
  logic [IDX_W-1:0]  dstIdxQ, baseIdxQ;

  // step size chosen by prefix count
  always_comb begin
    unique case (extCount)
      2'd0:    step = ADDR_W'(UNIT_STEP);
      2'd1:    step = {{PAD_W{1'b0}}, extImm[SHORT_IMM_W-1:0]};
      default: step = extImm;
    endcase
  end

  // modulo 2^ADDR_W arithmetic
  assign sumPtr  = baseVal + step;
  assign diffPtr = baseVal - step;

  always_comb begin
    unique case (mode)
      MODE_POST_INC: begin nextPtr = sumPtr;  accAddr = baseVal; end
      MODE_POST_DEC: begin nextPtr = diffPtr; accAddr = baseVal; end
      MODE_PRE_DEC:  begin nextPtr = diffPtr; accAddr = diffPtr; end
      default:       begin nextPtr = baseVal; accAddr = baseVal; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      ptrQ     <= '0;
      dstIdxQ  <= '0;
      baseIdxQ <= '0;
    end else if (strb.latchOp) begin
      addrQ    <= accAddr;
      ptrQ     <= nextPtr;
      dstIdxQ  <= dstSel;
      baseIdxQ <= baseSel;
    end
  end

  // upper byte of the word is dropped here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dataQ <= '0;
    else if (strb.captureData) dataQ <= memData[ADDR_W-1:0];
  end

  assign memAddr = addrQ;
  assign ptrData = ptrQ;
  assign dstData = dataQ;
  assign ptrIdx  = baseIdxQ;
  assign dstIdx  = dstIdxQ;
  assign sameIdx = (dstIdxQ == baseIdxQ);

endmodule

// File: rtl/autoidx_load_unit.sv
module autoidx_load_unit
  import aidx_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int REG_CNT     = 8,
  parameter int SHORT_IMM_W = 13,
  parameter int UNIT_STEP   = 4,
  localparam int IDX_W      = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [IDX_W-1:0]  dstSel,
  input  logic [IDX_W-1:0]  baseSel,
  input  logic [1:0]        extCount,
  input  logic [ADDR_W-1:0] extImm,
  input  logic [ADDR_W-1:0] baseVal,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic              dstWe,
  output logic [IDX_W-1:0]  dstIdx,
  output logic [ADDR_W-1:0] dstData,
  output logic              ptrWe,
  output logic [IDX_W-1:0]  ptrIdx,
  output logic [ADDR_W-1:0] ptrData
);

  dpStrobe_t strb;
  logic      sameIdx;
  idxMode_e  modeE;

  assign modeE = idxMode_e'(mode);

  aidx_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mode    (modeE),
    .sameIdx (sameIdx),
    .strb    (strb),
    .memReq  (memReq),
    .busy    (busy),
    .done    (done),
    .dstWe   (dstWe),
    .ptrWe   (ptrWe)
  );

  aidx_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REG_CNT     (REG_CNT),
    .SHORT_IMM_W (SHORT_IMM_W),
    .UNIT_STEP   (UNIT_STEP)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .mode     (modeE),
    .extCount (extCount),
    .extImm   (extImm),
    .baseVal  (baseVal),
    .dstSel   (dstSel),
    .baseSel  (baseSel),
    .memData  (memData),
    .memAddr  (memAddr),
    .ptrData  (ptrData),
    .dstData  (dstData),
    .ptrIdx   (ptrIdx),
    .dstIdx   (dstIdx),
    .sameIdx  (sameIdx)
  );

endmodule

// File: rtl/aidx_load_chk.sv
module aidx_load_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             memReq,
  input logic             busy,
  input logic             done,
  input logic             dstWe,
  input logic             ptrWe,
  input logic [IDX_W-1:0] dstIdx,
  input logic [IDX_W-1:0] ptrIdx
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !dstWe && !ptrWe && !done));

  // R8
  req_then_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> (done && dstWe && !memReq));

  // R8
  commit_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq));

  // R8
  commit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  write_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dstWe && ptrWe) |-> (dstIdx != ptrIdx));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !memReq);

endmodule

bind autoidx_load_unit aidx_load_chk #(.IDX_W(IDX_W)) i_aidx_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .memReq (memReq),
  .busy   (busy),
  .done   (done),
  .dstWe  (dstWe),
  .ptrWe  (ptrWe),
  .dstIdx (dstIdx),
  .ptrIdx (ptrIdx)
);

// File: tb/test_autoidx_load_unit.sv
module test_autoidx_load_unit;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  ext;
    logic [23:0] imm;
    logic [2:0]  dst;
    logic [2:0]  base;
    logic [23:0] init;
    logic [23:0] expAddr;
    logic [23:0] expPtr;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 24'h000000, 3'd1, 3'd2, 24'h001000, 24'h001000, 24'h001004}, // R2 R5
    '{2'd1, 2'd0, 24'h000000, 3'd3, 3'd4, 24'h000010, 24'h000010, 24'h00000C}, // R3 R5
    '{2'd2, 2'd0, 24'h000000, 3'd5, 3'd6, 24'h000100, 24'h0000FC, 24'h0000FC}, // R4 R5
    '{2'd0, 2'd1, 24'hFF1FFF, 3'd0, 3'd7, 24'h200000, 24'h200000, 24'h201FFF}, // R5 short mask
    '{2'd2, 2'd2, 24'h123456, 3'd2, 3'd1, 24'h500000, 24'h3DCBAA, 24'h3DCBAA}, // R5 full imm
    '{2'd0, 2'd0, 24'h000000, 3'd4, 3'd5, 24'hFFFFFE, 24'hFFFFFE, 24'h000002}, // R6 top wrap
    '{2'd2, 2'd1, 24'h000010, 3'd6, 3'd0, 24'h000008, 24'hFFFFF8, 24'hFFFFF8}, // R6 pre-dec wrap
    '{2'd1, 2'd2, 24'h000001, 3'd7, 3'd3, 24'h000000, 24'h000000, 24'hFFFFFF}, // R6 zero wrap
    '{2'd0, 2'd0, 24'h000000, 3'd3, 3'd3, 24'h000040, 24'h000040, 24'h000044}  // R9 same index
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [2:0]  dstSel = '0, baseSel = '0;
  logic [1:0]  extCount = '0;
  logic [23:0] extImm = '0;
  logic [23:0] baseVal;
  logic        memReq, busy, done, dstWe, ptrWe;
  logic [23:0] memAddr, dstData, ptrData;
  logic [31:0] memData;
  logic [2:0]  dstIdx, ptrIdx;
  logic [23:0] rf [8];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // memory model: top byte non-zero so discarding it is visible
  function automatic logic [31:0] memFn(input logic [23:0] a);
    return {a[7:0] ^ 8'hC3, ~a};
  endfunction

  assign memData = memFn(memAddr);
  assign baseVal = rf[baseSel];

  always @(posedge clk) begin
    if (dstWe) rf[dstIdx] <= dstData;
    if (ptrWe) rf[ptrIdx] <= ptrData;
  end

  autoidx_load_unit i_autoidx_load_unit (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .dstSel(dstSel), .baseSel(baseSel), .extCount(extCount),
    .extImm(extImm), .baseVal(baseVal), .memReq(memReq),
    .memAddr(memAddr), .memData(memData), .busy(busy), .done(done),
    .dstWe(dstWe), .dstIdx(dstIdx), .dstData(dstData),
    .ptrWe(ptrWe), .ptrIdx(ptrIdx), .ptrData(ptrData)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearRf();
    for (int i = 0; i < 8; i++) rf[i] = 24'h0A0A00 + 24'(i);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearRf();
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, memReq, done, dstWe, ptrWe} == 5'b0, "R1",
          32'({busy, memReq, done, dstWe, ptrWe}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      vec_t t;
      string mtag;
      t = VECS[v];
      mtag = (t.mode == 2'd0) ? "R2" : (t.mode == 2'd1) ? "R3" : "R4";
      clearRf();
      rf[t.base] = t.init;
      mode = t.mode; extCount = t.ext; extImm = t.imm;
      dstSel = t.dst; baseSel = t.base; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R8 issue cycle
      check(memReq && busy && !done, "R8 issue",
            32'({memReq, busy, done}), 32'b110);
      check(memAddr == t.expAddr, mtag, 32'(memAddr), 32'(t.expAddr));
      @(negedge clk);
      // R8 commit cycle
      check(done && busy && dstWe && !memReq, "R8 commit",
            32'({done, busy, dstWe, memReq}), 32'b1110);
      @(negedge clk);
      check(!busy && !done, "R8 idle", 32'({busy, done}), 32'b0);
      // R7 only low 24 bits land in the destination
      check(rf[t.dst] == memFn(t.expAddr)[23:0], "R7",
            32'(rf[t.dst]), 32'(memFn(t.expAddr)[23:0]));
      if (t.dst != t.base)
        check(rf[t.base] == t.expPtr, {mtag, " R5 R6 pointer"},
              32'(rf[t.base]), 32'(t.expPtr));
      else
        check(rf[t.base] == memFn(t.expAddr)[23:0], "R9",
              32'(rf[t.base]), 32'(memFn(t.expAddr)[23:0]));
    end

    // R10: start held through busy operation is ignored
    clearRf();
    rf[1] = 24'h000100; rf[5] = 24'h000500;
    mode = 2'd0; extCount = 2'd0; dstSel = 3'd2; baseSel = 3'd1; start = 1'b1;
    @(negedge clk);
    dstSel = 3'd6; baseSel = 3'd5;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(!busy && !memReq, "R10 no second op", 32'({busy, memReq}), 32'b0);
    check(rf[5] == 24'h000500, "R10 base untouched", 32'(rf[5]), 32'h500);
    check(rf[6] == 24'h0A0A06, "R10 dest untouched", 32'(rf[6]), 32'h0A0A06);
    check(rf[1] == 24'h000104, "R10 first op", 32'(rf[1]), 32'h104);

    // R11: reserved mode code is ignored
    clearRf();
    rf[4] = 24'h000800;
    mode = 2'd3; dstSel = 3'd2; baseSel = 3'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && !memReq, "R11 stays idle", 32'({busy, memReq}), 32'b0);
    @(negedge clk);
    @(negedge clk);
    check(rf[4] == 24'h000800 && rf[2] == 24'h0A0A02, "R11 no writes",
          32'(rf[4]), 32'h800);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule